// File: doc/BRIEF.md
# Hideable Flash Region Guard

This block decides, for each flash access offered to it, whether that access may reach a protected window of pages that holds boot-time secrets. The window starts at a configured start page and runs through a configured end page. A run-time extension count adds further pages directly after the end page. Right after reset, code and constants in the window can still be fetched and read, so the earliest boot stage can use its own keys. Once software seals the window, every access that lands in it is refused until the next reset.

A later boot stage can raise the extension count to hide its own parameters behind the ones already sealed. Writes into the window are always refused, because the window holds immutable boot material. Every refused access sets a sticky violation flag, which software clears.

The seal is kept by a two-state machine. `ST_OPEN` is the reset state. The transition `T_SEAL` moves it from `ST_OPEN` to `ST_SEALED` on a control write with the seal bit set. `ST_SEALED` has only the self-loop `T_HOLD` and is left only through reset.

Top module: `hide_region_guard`

## Requirements
- R1: During and right after reset, `chk_allow` reads 1 and `viol_flag` reads 0. The machine is in `ST_OPEN` and the extension count is zero.
- R2: In `ST_OPEN`, fetch (`chk_kind`=0) and read (`chk_kind`=1) accesses to window pages are allowed. Write-class kinds (`chk_kind[1]`=1, that is write=2 and reserved=3) into the window are refused at any time. The verdict appears on `chk_allow` one clock after the access is presented with `chk_valid`.
- R3: A control write (`reg_sel`=0) with bit 0 of `reg_wdata` set takes `T_SEAL`. A control write with bit 0 clear leaves the seal unchanged. Nothing except reset leaves `ST_SEALED`.
- R4: In `ST_SEALED`, every access of any kind whose page lies in the window is refused. Accesses outside the window are always allowed.
- R5: An extension write (`reg_sel`=1) loads `reg_wdata` as a count of extra pages. The window then covers pages from the start page through the end page plus that count. In `ST_OPEN`, any value is accepted.
- R6: In `ST_SEALED`, an extension write whose value is below the current count is ignored. An equal or larger value is accepted.
- R7: A refused access sets `viol_flag` one clock later. A control write with bit 1 set clears the flag, and a write with bit 1 clear leaves it as it is. If a refusal and a clear happen in the same cycle, the refusal wins.
- R8: Addresses are compared per page, where page = `chk_addr` / 2048. The first and last bytes of a page get the same verdict as that page.
- R9: When `chk_valid` is low, `chk_allow` reads 1 on the next cycle and the violation flag is not set.
- R10: Reset returns the machine to `ST_OPEN` and clears the extension count, so previously hidden pages can be fetched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_page | input | ADDR_W-11 | First page of the window, static after reset |
| cfg_end_page | input | ADDR_W-11 | Last base page of the window, static after reset |
| chk_valid | input | 1 | An access is offered this cycle |
| chk_addr | input | ADDR_W | Byte address of the access |
| chk_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 reserved (write class) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 control, 1 extension count |
| reg_wdata | input | REG_W | Write data |
| chk_allow | output | 1 | Registered verdict for the previous cycle's access |
| viol_flag | output | 1 | Sticky refused-access flag |

## Verification
The assertions assume that the start and end page inputs stay constant between resets and that the end page is not below the start page. The bench therefore sets them once, before reset is released, and never moves them. The assertions also assume that `chk_addr` and `chk_kind` are meaningful only while `chk_valid` is high. The stimulus drives every input on the falling edge and holds it for one full cycle, so the registered verdict is sampled only after it has settled.

// File: rtl/hrg_pkg.sv
package hrg_pkg;

    typedef enum logic [0:0] {
        ST_OPEN   = 1'b0,
        ST_SEALED = 1'b1
    } seal_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_EXT  = 2'd1;

    localparam int CTRL_SEAL_BIT = 0;
    localparam int CTRL_CLR_BIT  = 1;

    // access kinds with bit 1 set belong to the write class
    localparam int KIND_WRITE_BIT = 1;

endpackage

// File: rtl/hrg_fsm.sv
module hrg_fsm
    import hrg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    output logic sealed
);

    seal_state_e state_q;
    seal_state_e state_d;

    // next-state: T_SEAL leaves ST_OPEN, T_HOLD keeps ST_SEALED
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:   state_d = seal_req ? ST_SEALED : ST_OPEN;
            ST_SEALED: state_d = ST_SEALED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        sealed = 1'b0;
        unique case (state_q)
            ST_OPEN:   sealed = 1'b0;
            ST_SEALED: sealed = 1'b1;
        endcase
    end

endmodule

// File: rtl/hrg_extreg.sv
module hrg_extreg #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_val,
    input  logic             sealed,
    output logic [REG_W-1:0] ext_cnt
);

    logic [REG_W-1:0] ext_q;
    logic             accept;

    // once sealed the window may only grow
    assign accept = wr_en && (!sealed || (wr_val >= ext_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ext_q <= '0;
        else if (accept) ext_q <= wr_val;
    end

    assign ext_cnt = ext_q;

endmodule

// File: rtl/hrg_match.sv
module hrg_match #(
    parameter int ADDR_W     = 20,
    parameter int PAGE_SHIFT = 11,
    parameter int REG_W      = 8
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] start_page,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] end_page,
    input  logic [REG_W-1:0]             ext_cnt,
    output logic                         hit
);

    localparam int CMP_W = ((ADDR_W > REG_W) ? ADDR_W : REG_W) + 1;

    logic [CMP_W-1:0] page;
    logic [CMP_W-1:0] lo;
    logic [CMP_W-1:0] hi;

    // widened compare so that end page plus extension never wraps
    assign page = CMP_W'(addr >> PAGE_SHIFT);
    assign lo   = CMP_W'(start_page);
    assign hi   = CMP_W'(end_page) + CMP_W'(ext_cnt);
    assign hit  = (page >= lo) && (page <= hi);

endmodule

// File: rtl/hrg_resp.sv
module hrg_resp (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_valid,
    input  logic hit,
    input  logic sealed,
    input  logic write_class,
    input  logic viol_clr,
    output logic allow,
    output logic viol
);

    logic deny;
    logic allow_q;
    logic viol_q;

    assign deny = chk_valid && hit && (sealed || write_class);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            allow_q <= 1'b1;
            viol_q  <= 1'b0;
        end else begin
            allow_q <= !deny;
            viol_q  <= deny || (viol_q && !viol_clr);
        end
    end

    assign allow = allow_q;
    assign viol  = viol_q;

endmodule

// File: rtl/hide_region_guard.sv
module hide_region_guard
    import hrg_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_BYTES = 2048,
    parameter int REG_W      = 8,
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] cfg_start_page,
    input  logic [PAGE_W-1:0] cfg_end_page,
    input  logic              chk_valid,
    input  logic [ADDR_W-1:0] chk_addr,
    input  logic [1:0]        chk_kind,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              chk_allow,
    output logic              viol_flag
);

    logic             ctrl_wr;
    logic             ext_wr;
    logic             seal_req;
    logic             viol_clr;
    logic             sealed;
    logic             hit;
    logic [REG_W-1:0] ext_cnt;

    assign ctrl_wr  = reg_wr && (reg_sel == SEL_CTRL);
    assign ext_wr   = reg_wr && (reg_sel == SEL_EXT);
    assign seal_req = ctrl_wr && reg_wdata[CTRL_SEAL_BIT];
    assign viol_clr = ctrl_wr && reg_wdata[CTRL_CLR_BIT];

    hrg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .seal_req (seal_req),
        .sealed   (sealed)
    );

    hrg_extreg #(.REG_W(REG_W)) u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ext_wr),
        .wr_val  (reg_wdata),
        .sealed  (sealed),
        .ext_cnt (ext_cnt)
    );

    hrg_match #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .REG_W      (REG_W)
    ) u_match (
        .addr       (chk_addr),
        .start_page (cfg_start_page),
        .end_page   (cfg_end_page),
        .ext_cnt    (ext_cnt),
        .hit        (hit)
    );

    hrg_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_valid   (chk_valid),
        .hit         (hit),
        .sealed      (sealed),
        .write_class (chk_kind[KIND_WRITE_BIT]),
        .viol_clr    (viol_clr),
        .allow       (chk_allow),
        .viol        (viol_flag)
    );

endmodule

// File: rtl/hrg_checker.sv
module hrg_checker #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_valid,
    input logic [1:0]       chk_kind,
    input logic             reg_wr,
    input logic [1:0]       reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic             chk_allow,
    input logic             viol_flag,
    input logic             sealed,
    input logic             hit,
    input logic [REG_W-1:0] ext_cnt
);

    logic clr_now;
    assign clr_now = reg_wr && (reg_sel == 2'd0) && reg_wdata[1];

    a_r2_open_fetch_read: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !sealed && !chk_kind[1]) |=> chk_allow);

    a_r3_seal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> sealed);

    a_r4_outside_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && !hit) |=> chk_allow);

    a_r4_sealed_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && hit && sealed) |=> (!chk_allow && viol_flag));

    a_r6_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        sealed |=> (ext_cnt >= $past(ext_cnt)));

    a_r7_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !clr_now) |=> viol_flag);

    a_r9_idle_allows: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> chk_allow);

endmodule

bind hide_region_guard hrg_checker #(.REG_W(REG_W)) i_hrg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_kind  (chk_kind),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .chk_allow (chk_allow),
    .viol_flag (viol_flag),
    .sealed    (sealed),
    .hit       (hit),
    .ext_cnt   (ext_cnt)
);

// File: tb/test_hide_region_guard.sv
`timescale 1ns/1ps
module test_hide_region_guard;

    localparam int ADDR_W = 20;
    localparam int REG_W  = 8;
    localparam int PAGE_W = ADDR_W - 11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PAGE_W-1:0] cfg_start_page = PAGE_W'(8);
    logic [PAGE_W-1:0] cfg_end_page   = PAGE_W'(11);
    logic              chk_valid = 1'b0;
    logic [ADDR_W-1:0] chk_addr  = '0;
    logic [1:0]        chk_kind  = '0;
    logic              reg_wr    = 1'b0;
    logic [1:0]        reg_sel   = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic              chk_allow;
    logic              viol_flag;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    hide_region_guard #(.ADDR_W(ADDR_W), .REG_W(REG_W)) i_hide_region_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_page(cfg_start_page), .cfg_end_page(cfg_end_page),
        .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_kind(chk_kind),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .chk_allow(chk_allow), .viol_flag(viol_flag)
    );

    // op 0 = access (data is address), op 1 = register write (sel, data)
    typedef struct packed {
        logic        op;
        logic [1:0]  sel;
        logic [19:0] data;
        logic [1:0]  kind;
        logic        ea;
        logic        ev;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 28;
    // window: pages 8..11 (0x4000..0x5FFF), extension adds pages from 12
    localparam vec_t VEC [NV] = '{
        '{1'b0, 2'd0, 20'h04000, 2'd0, 1'b1, 1'b0, 4'd2},  // R2 fetch open
        '{1'b0, 2'd0, 20'h05FFF, 2'd1, 1'b1, 1'b0, 4'd2},  // R2 read last byte
        '{1'b0, 2'd0, 20'h04800, 2'd2, 1'b0, 1'b1, 4'd2},  // R2 write refused
        '{1'b1, 2'd0, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd7},  // R7 clear
        '{1'b0, 2'd0, 20'h03FFF, 2'd2, 1'b1, 1'b0, 4'd8},  // R8 page 7 write ok
        '{1'b1, 2'd1, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd5},  // R5 ext=2
        '{1'b0, 2'd0, 20'h06000, 2'd1, 1'b1, 1'b0, 4'd5},  // R5 ext page read open
        '{1'b1, 2'd0, 20'h00000, 2'd0, 1'b1, 1'b0, 4'd3},  // R3 zero write
        '{1'b0, 2'd0, 20'h04000, 2'd0, 1'b1, 1'b0, 4'd3},  // R3 still open
        '{1'b1, 2'd0, 20'h00001, 2'd0, 1'b1, 1'b0, 4'd3},  // R3 seal
        '{1'b0, 2'd0, 20'h04000, 2'd0, 1'b0, 1'b1, 4'd4},  // R4 fetch refused
        '{1'b1, 2'd0, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd7},  // R7 clear
        '{1'b0, 2'd0, 20'h03FFF, 2'd1, 1'b1, 1'b0, 4'd8},  // R8 page 7 ok
        '{1'b0, 2'd0, 20'h06000, 2'd1, 1'b0, 1'b1, 4'd5},  // R5 page 12 hidden
        '{1'b1, 2'd0, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd7},
        '{1'b0, 2'd0, 20'h06FFF, 2'd0, 1'b0, 1'b1, 4'd5},  // R5 page 13 hidden
        '{1'b1, 2'd0, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd7},
        '{1'b0, 2'd0, 20'h07000, 2'd1, 1'b1, 1'b0, 4'd8},  // R8 page 14 ok
        '{1'b1, 2'd1, 20'h00001, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 shrink ignored
        '{1'b0, 2'd0, 20'h06800, 2'd1, 1'b0, 1'b1, 4'd6},  // R6 page 13 still hidden
        '{1'b1, 2'd0, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd7},
        '{1'b1, 2'd1, 20'h00003, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 grow
        '{1'b0, 2'd0, 20'h07000, 2'd0, 1'b0, 1'b1, 4'd6},  // R6 page 14 hidden
        '{1'b1, 2'd0, 20'h00000, 2'd0, 1'b1, 1'b1, 4'd7},  // R7 flag stays
        '{1'b1, 2'd0, 20'h00002, 2'd0, 1'b1, 1'b0, 4'd7},  // R7 clear
        '{1'b0, 2'd0, 20'h07800, 2'd1, 1'b1, 1'b0, 4'd4},  // R4 page 15 outside
        '{1'b0, 2'd0, 20'h05000, 2'd3, 1'b0, 1'b1, 4'd4},  // R4 reserved kind
        '{1'b1, 2'd0, 20'h00003, 2'd0, 1'b1, 1'b0, 4'd3}   // R3 reseal + clear
    };

    task automatic check(input int req, input string what, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic step(input logic op, input logic [1:0] sel, input logic [19:0] data,
                        input logic [1:0] kind);
        @(negedge clk);
        if (op) begin
            reg_wr = 1'b1; reg_sel = sel; reg_wdata = data[REG_W-1:0];
        end else begin
            chk_valid = 1'b1; chk_addr = data; chk_kind = kind;
        end
        @(negedge clk);
        reg_wr = 1'b0; chk_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, "allow in reset", chk_allow, 1'b1);   // R1
        check(1, "viol in reset", viol_flag, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "allow after reset", chk_allow, 1'b1);
        check(1, "viol after reset", viol_flag, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].sel, VEC[i].data, VEC[i].kind);
            check(int'(VEC[i].req), $sformatf("vec %0d allow", i), chk_allow, VEC[i].ea);
            check(int'(VEC[i].req), $sformatf("vec %0d viol", i), viol_flag, VEC[i].ev);
        end

        // R9: idle cycles with a window address on the bus but valid low
        chk_addr = 20'h04000;
        repeat (3) @(negedge clk);
        check(9, "idle allow", chk_allow, 1'b1);
        check(9, "idle viol", viol_flag, 1'b0);

        // R7: refusal and clear in the same cycle, refusal wins
        @(negedge clk);
        chk_valid = 1'b1; chk_addr = 20'h04000; chk_kind = 2'd1;
        reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h02;
        @(negedge clk);
        chk_valid = 1'b0; reg_wr = 1'b0;
        check(7, "set beats clear viol", viol_flag, 1'b1);
        check(7, "set beats clear allow", chk_allow, 1'b0);

        // R10 / R1: reset reopens and clears the extension
        rst_n = 1'b0;
        @(negedge clk);
        check(1, "reset allow", chk_allow, 1'b1);
        check(1, "reset viol", viol_flag, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 2'd0, 20'h04000, 2'd0);
        check(10, "fetch after reset", chk_allow, 1'b1);
        step(1'b1, 2'd0, 20'h00001, 2'd0);
        step(1'b0, 2'd0, 20'h06000, 2'd1);
        check(10, "ext cleared page 12 ok", chk_allow, 1'b1);
        check(10, "ext cleared viol", viol_flag, 1'b0);
        step(1'b0, 2'd0, 20'h04000, 2'd0);
        check(10, "resealed base refused", chk_allow, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule